// File: doc/BRIEF.md
# Sequential Byte Multiply and Divide Unit

This unit performs unsigned byte multiplication and unsigned byte division over a fixed run of clock cycles. It sits beside an accumulator-style datapath. A one-cycle `start` pulse, together with an operation select and two operand bytes (`a_in` acting as accumulator, `b_in` as the auxiliary register), launches a run. Exactly four cycles later the unit presents new values for both registers, plus carry and overflow flags, and marks them with a single-cycle `done` pulse.

A multiply returns its double-width product split across the two result bytes. A divide returns the quotient and the remainder. Both operations use one shared working register. A parameterised number of shift-and-add steps (multiply) or restoring-subtraction steps (divide) is unrolled into each cycle. With the default width of 8 bits and 4 cycles, each cycle retires 2 bits.

The operands are latched when the run is accepted. The results stay on the outputs until the next run finishes.

Top module: `mdu_core`

## Requirements
- R1: While reset is asserted, `a_out`, `b_out`, `ov_out`, `cy_out` and `done` are all 0.
- R2: For a multiply (`op`=0), `a_out` carries bits 7..0 of the 16-bit product `a_in*b_in` and `b_out` carries bits 15..8.
- R3: A multiply sets `ov_out` when the product is greater than 0xFF and clears it otherwise. `cy_out` is 0 after every operation.
- R4: For a divide (`op`=1) with a nonzero divisor, `a_out` is the quotient `a_in/b_in`, `b_out` is the remainder, and `ov_out` and `cy_out` are 0.
- R5: A divide by a zero `b_in` sets `ov_out`, leaves `cy_out` at 0, and returns `a_out`=0xFF and `b_out` equal to the dividend `a_in`.
- R6: A `start` accepted at clock edge k makes `done` high for exactly one cycle, from edge k+4 to edge k+5, and the new results appear at edge k+4.
- R7: A `start` seen at any of edges k+1 to k+4 after an accepted `start` at edge k is ignored. It neither restarts nor alters the run in progress.
- R8: `op`, `a_in` and `b_in` are sampled only at the accepting edge. Changing them during a run does not change its results.
- R9: `a_out`, `b_out` and `ov_out` hold their values in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run when the unit is idle |
| op | input | 1 | Operation select: 0 multiply, 1 divide |
| a_in | input | W | Accumulator operand (multiplicand or dividend) |
| b_in | input | W | Auxiliary operand (multiplier or divisor) |
| a_out | output | W | New accumulator value |
| b_out | output | W | New auxiliary register value |
| cy_out | output | 1 | Carry flag result, always cleared |
| ov_out | output | 1 | Overflow flag: product above one byte, or zero divisor |
| done | output | 1 | One-cycle completion strobe |

## Verification
The results, flags and `done` of a run accepted at edge k are due together at edge k+4. Every output is held constant at every other edge.

The bench keeps its own reference: an idle/busy state with a cycle count that advances on each rising edge. It loads the expected bytes only when its count reaches four. All outputs are compared against this reference at every falling edge, so an early, late, repeated or missing result shows up as a mismatch in that same half cycle.

Stimulus deliberately holds `start` high through busy cycles and scrambles the operands mid-run. Ignored launches and late operand changes are therefore judged by the very same per-cycle comparison.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   typedef enum logic {
      MDU_MUL = 1'b0,
      MDU_DIV = 1'b1
   } mdu_op_e;

endpackage

// File: rtl/mdu_seq.sv
// Run controller: accepts a launch when idle, counts STEPS iteration cycles,
// then raises a one-cycle completion strobe.
module mdu_seq #(
   parameter int STEPS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic busy,
   output logic last_step,
   output logic done
);

   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   generate
      if (STEPS < 1) begin : g_bad_steps
         $error("mdu_seq: STEPS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign accept    = start & ~busy;
   assign last_step = busy & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            if (cnt == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R6: an accepted launch always enters the busy phase
   assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
   // R6: completion strobe lasts one cycle
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: a launch during a run never resets the step count
   assert_busy_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last_step) |=> (busy && cnt != '0));

endmodule

// File: rtl/mdu_mul_step.sv
// BPS unrolled shift-and-add iterations on {carry, high, low} work register.
module mdu_mul_step #(
   parameter int W   = 8,
   parameter int BPS = 2
) (
   input  logic [2*W:0]   cur,
   input  logic [W-1:0]   mcand,
   output logic [2*W:0]   nxt
);

   always_comb begin
      logic [2*W:0] p;
      p = cur;
      for (int i = 0; i < BPS; i++) begin
         if (p[0]) begin
            p[2*W:W] = {1'b0, p[2*W-1:W]} + {1'b0, mcand};
         end
         p = p >> 1;
      end
      nxt = p;
   end

endmodule

// File: rtl/mdu_div_step.sv
// BPS unrolled restoring-division iterations on {remainder, quotient} register.
module mdu_div_step #(
   parameter int W   = 8,
   parameter int BPS = 2
) (
   input  logic [2*W-1:0] cur,
   input  logic [W-1:0]   divisor,
   output logic [2*W-1:0] nxt
);

   always_comb begin
      logic [W:0]   r;
      logic [W-1:0] q;
      logic [W-1:0] rem;
      rem = cur[2*W-1:W];
      q   = cur[W-1:0];
      for (int i = 0; i < BPS; i++) begin
         r = {rem, q[W-1]};
         q = {q[W-2:0], 1'b0};
         if (r >= {1'b0, divisor}) begin
            r    = r - {1'b0, divisor};
            q[0] = 1'b1;
         end
         rem = r[W-1:0];
      end
      nxt = {rem, q};
   end

endmodule

// File: rtl/mdu_core.sv
module mdu_core
   import mdu_pkg::*;
#(
   parameter int W     = 8,
   parameter int STEPS = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         op,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] b_out,
   output logic         cy_out,
   output logic         ov_out,
   output logic         done
);

   localparam int BPS = W / STEPS;
   localparam int W2  = 2 * W;

   generate
      if (W < 2) begin : g_bad_width
         $error("mdu_core: W must be at least 2");
      end
      if ((STEPS < 1) || (W % STEPS != 0)) begin : g_bad_split
         $error("mdu_core: STEPS must divide W");
      end
   endgenerate

   logic          accept, busy, last_step;
   mdu_op_e       op_q;
   logic [W-1:0]  a_q, b_q;
   logic [W2:0]   work;
   logic [W2:0]   mul_nxt;
   logic [W2-1:0] div_nxt;

   mdu_seq #(.STEPS(STEPS)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .accept    (accept),
      .busy      (busy),
      .last_step (last_step),
      .done      (done)
   );

   mdu_mul_step #(.W(W), .BPS(BPS)) i_mul (
      .cur   (work),
      .mcand (b_q),
      .nxt   (mul_nxt)
   );

   mdu_div_step #(.W(W), .BPS(BPS)) i_div (
      .cur     (work[W2-1:0]),
      .divisor (b_q),
      .nxt     (div_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= MDU_MUL;
         a_q    <= '0;
         b_q    <= '0;
         work   <= '0;
         a_out  <= '0;
         b_out  <= '0;
         ov_out <= 1'b0;
      end else if (accept) begin
         op_q <= mdu_op_e'(op);
         a_q  <= a_in;
         b_q  <= b_in;
         work <= {{(W+1){1'b0}}, a_in};
      end else if (busy) begin
         if (op_q == MDU_MUL) begin
            work <= mul_nxt;
         end else begin
            work <= {1'b0, div_nxt};
         end
         if (last_step) begin
            if (op_q == MDU_MUL) begin
               a_out  <= mul_nxt[W-1:0];
               b_out  <= mul_nxt[W2-1:W];
               ov_out <= |mul_nxt[W2-1:W];
            end else begin
               a_out  <= div_nxt[W-1:0];
               b_out  <= div_nxt[W2-1:W];
               ov_out <= (b_q == '0);
            end
         end
      end
   end

   assign cy_out = 1'b0;

   // R2: full product split across the two result bytes
   assert_mul_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == MDU_MUL) |-> ({b_out, a_out} == ({{W{1'b0}}, a_q} * {{W{1'b0}}, b_q})));
   // R3: overflow means the high byte is nonzero
   assert_mul_ov_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == MDU_MUL) |-> (ov_out == (b_out != '0)));
   // R4: quotient and remainder reconstruct the dividend
   assert_div_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == MDU_DIV && b_q != '0) |->
      (({{W{1'b0}}, a_out} * {{W{1'b0}}, b_q} + {{W{1'b0}}, b_out} == {{W{1'b0}}, a_q})
       && (b_out < b_q) && !ov_out));
   // R5: zero divisor result pattern
   assert_div_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == MDU_DIV && b_q == '0) |-> (ov_out && a_out == '1 && b_out == a_q));
   // R6: completion only ends a busy phase
   assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));
   // R9: results hold between completions
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(a_out) && $stable(b_out) && $stable(ov_out)));

endmodule

// File: tb/test_mdu_core.sv
`timescale 1ns/1ps
module test_mdu_core;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         op = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic         cy_out, ov_out, done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string ph = "R1";

   // reference model state
   bit       m_busy = 0;
   int       m_cnt = 0;
   bit       m_op = 0;
   int       m_a = 0, m_b = 0;
   int       e_a = 0, e_b = 0;
   bit       e_ov = 0, e_done = 0;
   string    m_tag = "R1";

   always #2.5 clk = ~clk;

   mdu_core #(.W(W), .STEPS(4)) i_mdu_core (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
      .cy_out(cy_out), .ov_out(ov_out), .done(done)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s got %0h expected %0h (t=%0t)", req, what, got, exp, $time);
      end
   endtask

   // behavioural reference: idle/busy with a four-edge countdown
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_cnt = 0; e_a = 0; e_b = 0; e_ov = 0; e_done = 0;
      end else begin
         e_done = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == 4) begin
               m_busy = 0;
               e_done = 1;
               if (!m_op) begin
                  int p;
                  p = m_a * m_b;
                  e_a = p % 256; e_b = p / 256; e_ov = (p > 255);
                  m_tag = e_ov ? "R3" : "R2";
               end else if (m_b == 0) begin
                  e_a = 255; e_b = m_a; e_ov = 1; m_tag = "R5";
               end else begin
                  e_a = m_a / m_b; e_b = m_a % m_b; e_ov = 0; m_tag = "R4";
               end
            end
         end else if (start) begin
            m_busy = 1; m_cnt = 0; m_op = op; m_a = int'(a_in); m_b = int'(b_in);
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk({ph, "/R6"}, "done", int'(done), int'(e_done));
         chk({ph, "/", m_tag}, "a_out", int'(a_out), e_a);
         chk({ph, "/", m_tag}, "b_out", int'(b_out), e_b);
         chk({ph, "/", m_tag}, "ov_out", int'(ov_out), int'(e_ov));
         chk({ph, "/R3"}, "cy_out", int'(cy_out), 0);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // one launch; operands scrambled after the accepting edge (R8)
   task automatic run(input bit o, input int a, input int b);
      @(negedge clk);
      start = 1'b1; op = o; a_in = W'(a); b_in = W'(b);
      @(negedge clk);
      start = 1'b0; op = ~o; a_in = W'($urandom); b_in = W'($urandom);
      repeat (5) @(negedge clk);
   endtask

   initial begin
      // R1: reset values
      repeat (3) @(negedge clk);
      chk("R1", "a_out", int'(a_out), 0);
      chk("R1", "b_out", int'(b_out), 0);
      chk("R1", "ov_out", int'(ov_out), 0);
      chk("R1", "done", int'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      ph = "R4"; run(1, 251, 18);          // quotient 13, remainder 17
      chk("R4", "a_out 251/18", int'(a_out), 13);
      chk("R4", "b_out 251/18", int'(b_out), 17);
      ph = "R3"; run(0, 'h50, 'hA0);       // product 0x3200
      chk("R2", "a_out 50*A0", int'(a_out), 'h00);
      chk("R2", "b_out 50*A0", int'(b_out), 'h32);
      chk("R3", "ov 50*A0", int'(ov_out), 1);
      ph = "R2"; run(0, 3, 5);
      chk("R3", "ov 3*5", int'(ov_out), 0);
      run(0, 'hFF, 'hFF);
      run(0, 0, 'hFF);
      ph = "R5"; run(1, 'h5A, 0);
      chk("R5", "a_out zero div", int'(a_out), 'hFF);
      chk("R5", "b_out zero div", int'(b_out), 'h5A);
      ph = "R4"; run(1, 7, 9);
      run(1, 200, 1);
      run(1, 255, 255);

      // R7: start held high through a run and its busy cycles
      ph = "R7";
      @(negedge clk);
      start = 1'b1; op = 1'b0; a_in = 8'd12; b_in = 8'd11;
      @(negedge clk);
      a_in = 8'd99; b_in = 8'd0; op = 1'b1;
      repeat (8) @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);

      // R9: long idle stretch, outputs must hold
      ph = "R9";
      repeat (20) @(negedge clk);

      ph = "R8";
      for (int i = 0; i < 300; i++) begin
         run(1'($urandom), ($urandom % 8 == 0) ? 0 : int'($urandom % 256),
             ($urandom % 10 == 0) ? 0 : int'($urandom % 256));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule